// File: doc/BRIEF.md
# Backplane Bus Arbiter with Grant and Transfer Timeouts

This block is the arbiter of a backplane system controller fitted in the first slot. It samples four bus request levels and drives one of four grant outputs toward the daisy chain. A two-bit mode input picks the policy. Round-robin rotates service across the levels. Single-level serves level 3 only. Fixed priority always prefers the highest requesting level.

Once a grant is driven, the block waits for a master to assert bus-busy. If no master does so within a window of 16 or 256 microseconds, the block withdraws the grant and sets a sticky arbitration-timeout flag. A separate watchdog flags a data transfer whose strobe stays unanswered for too long. Both durations are counted in clock cycles from a cycles-per-microsecond parameter.

When the system-controller enable is low, the block stays passive so that another board can act as controller.

Top module: `bus_arb_ctrl`

## Requirements
- R1: After reset all grant outputs are 0, both timeout flags are 0, and the round-robin pointer holds level 0.
- R2: At most one grant bit is high at any time. A grant is registered: it appears on the clock edge that samples the request in the idle state with bus-busy low.
- R3: No new grant is issued while bus-busy is high. Once bus-busy has been low at a clock edge in the idle state, a pending request is granted at that edge.
- R4: With mode_sel = 2 or 3 (fixed priority), the highest-numbered requesting level is granted. grant[i] serves level i.
- R5: With mode_sel = 1 (single-level), only level 3 is served, and requests on levels 2..0 never produce a grant.
- R6: With mode_sel = 0 (round-robin), the search begins one level below the last level granted, wraps from level 0 to level 3, and reaches the last-granted level only at the end.
- R7: If bus-busy is high at a clock edge while a grant is driven, the grant drops at that edge and no timeout is flagged.
- R8: A grant that sees no bus-busy is held for exactly 16·TICKS_PER_US cycles when long_to was 0 at grant time, or 256·TICKS_PER_US cycles when it was 1. On the edge that removes the grant, arb_to_flag is set.
- R9: bus_to_flag is set after xfer_strobe has been high with xfer_ack low for BUS_TO_US·TICKS_PER_US consecutive cycles. Dropping the strobe, or raising ack, restarts the count.
- R10: Both flags are sticky. Each clears on a clock edge at which its clear input is high. A timeout occurring on the same edge as a clear wins over the clear.
- R11: While sys_en is low, the grant outputs go to 0 at the next edge and stay at 0, and the transfer watchdog does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_en | input | 1 | System-controller enable |
| mode_sel | input | 2 | 0 round-robin, 1 single-level, 2/3 fixed priority |
| long_to | input | 1 | Grant timeout select: 0 short, 1 long |
| bus_req | input | N_LVL | Request levels, active high |
| bus_busy | input | 1 | Bus-busy, active high |
| xfer_strobe | input | 1 | Data transfer strobe, active high |
| xfer_ack | input | 1 | Transfer acknowledge, active high |
| clr_arb_to | input | 1 | Clear arb_to_flag (write one to clear) |
| clr_bus_to | input | 1 | Clear bus_to_flag (write one to clear) |
| grant | output | N_LVL | One-hot grant outputs |
| arb_to_flag | output | 1 | Sticky arbitration timeout |
| bus_to_flag | output | 1 | Sticky transfer timeout |

## Verification
Fixed priority is driven with mixed request pairs, so any order other than highest-first gives a wrong grant. Round-robin is driven first with all levels requesting, which shows the 3-2-1-0 rotation and the wrap. It is then driven with a sparse pattern, which shows that idle levels are skipped. Single-level mode receives requests on the lower levels only, so a leak through those levels is visible. Unanswered grants are timed in both window settings to the exact cycle, and the transfer watchdog is run once to expiry and once with an interrupting acknowledge, which separates consecutive counting from cumulative counting.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    ARB_RR    = 2'd0,
    ARB_ONE   = 2'd1,
    ARB_FIX   = 2'd2,
    ARB_FIX_B = 2'd3
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_HELD  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/bus_arb_pick.sv
module bus_arb_pick
  import bus_arb_pkg::*;
#(
  parameter int N_LVL = 4,
  localparam int LW = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic [N_LVL-1:0] req,
  input  arb_mode_e        mode,
  input  logic [LW-1:0]    last,
  output logic             valid,
  output logic [LW-1:0]    lvl
);
  logic          pri_v, rr_v;
  logic [LW-1:0] pri_l, rr_l;

  // fixed priority: ascending scan, highest request overrides
  always_comb begin
    pri_v = 1'b0;
    pri_l = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (req[i]) begin
        pri_v = 1'b1;
        pri_l = LW'(i);
      end
    end
  end

  // rotating: offsets scanned far to near, nearest below 'last' wins
  always_comb begin
    rr_v = 1'b0;
    rr_l = '0;
    for (int k = N_LVL; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + N_LVL - k) % N_LVL;
      if (req[idx]) begin
        rr_v = 1'b1;
        rr_l = LW'(idx);
      end
    end
  end

  always_comb begin
    unique case (mode)
      ARB_RR: begin
        valid = rr_v;
        lvl   = rr_l;
      end
      ARB_ONE: begin
        valid = req[N_LVL-1];
        lvl   = LW'(N_LVL-1);
      end
      default: begin
        valid = pri_v;
        lvl   = pri_l;
      end
    endcase
  end
endmodule

// File: rtl/bus_arb_timer.sv
module bus_arb_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = run && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!hit) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int N_LVL         = 4,
  parameter int TICKS_PER_US  = 50,
  parameter int SHORT_US      = 16,
  parameter int LONG_US       = 256,
  parameter int BUS_TO_US     = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_en,
  input  logic [1:0]       mode_sel,
  input  logic             long_to,
  input  logic [N_LVL-1:0] bus_req,
  input  logic             bus_busy,
  input  logic             xfer_strobe,
  input  logic             xfer_ack,
  input  logic             clr_arb_to,
  input  logic             clr_bus_to,
  output logic [N_LVL-1:0] grant,
  output logic             arb_to_flag,
  output logic             bus_to_flag
);
  localparam int LW        = (N_LVL > 1) ? $clog2(N_LVL) : 1;
  localparam int SHORT_CYC = SHORT_US * TICKS_PER_US;
  localparam int LONG_CYC  = LONG_US * TICKS_PER_US;
  localparam int BUS_CYC   = BUS_TO_US * TICKS_PER_US;
  localparam int AW        = $clog2(LONG_CYC + 1);
  localparam int BW        = $clog2(BUS_CYC + 1);

  arb_state_e     state;
  logic [LW-1:0]  last_lvl;
  logic [AW-1:0]  win_lim;
  logic           pick_v;
  logic [LW-1:0]  pick_l;
  logic [N_LVL-1:0] pick_oh;
  logic           win_run, win_hit;
  logic           wd_run, wd_hit;

  bus_arb_pick #(.N_LVL(N_LVL)) u_pick (
    .req   (bus_req),
    .mode  (arb_mode_e'(mode_sel)),
    .last  (last_lvl),
    .valid (pick_v),
    .lvl   (pick_l)
  );

  assign pick_oh = N_LVL'(1) << pick_l;
  assign win_run = sys_en && (state == ST_OFFER) && !bus_busy;
  assign wd_run  = sys_en && xfer_strobe && !xfer_ack;

  bus_arb_timer #(.CW(AW)) u_win (
    .clk   (clk),
    .rst   (rst),
    .run   (win_run),
    .limit (win_lim),
    .hit   (win_hit)
  );

  bus_arb_timer #(.CW(BW)) u_wd (
    .clk   (clk),
    .rst   (rst),
    .run   (wd_run),
    .limit (BW'(BUS_CYC)),
    .hit   (wd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      grant       <= '0;
      last_lvl    <= '0;
      win_lim     <= AW'(SHORT_CYC);
      arb_to_flag <= 1'b0;
      bus_to_flag <= 1'b0;
    end else begin
      arb_to_flag <= (arb_to_flag && !clr_arb_to) || win_hit;
      bus_to_flag <= (bus_to_flag && !clr_bus_to) || wd_hit;
      if (!sys_en) begin
        state <= ST_IDLE;
        grant <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!bus_busy && pick_v) begin
              grant    <= pick_oh;
              last_lvl <= pick_l;
              win_lim  <= long_to ? AW'(LONG_CYC) : AW'(SHORT_CYC);
              state    <= ST_OFFER;
            end
          end
          ST_OFFER: begin
            if (bus_busy) begin
              grant <= '0;
              state <= ST_HELD;
            end else if (win_hit) begin
              grant <= '0;
              state <= ST_IDLE;
            end
          end
          ST_HELD: begin
            if (!bus_busy) state <= ST_IDLE;
          end
          default: begin
            grant <= '0;
            state <= ST_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int N_LVL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_en,
  input logic [1:0]       mode_sel,
  input logic             bus_busy,
  input logic             clr_arb_to,
  input logic [N_LVL-1:0] grant,
  input logic             arb_to_flag
);
  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_en |=> (grant == '0));

  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|grant) |-> $past(!bus_busy));

  // R5
  single_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(|grant) && ($past(mode_sel) == 2'd1)) |-> grant[N_LVL-1]);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && bus_busy && sys_en) |=> (grant == '0));

  // R8
  to_withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_to_flag) |-> $fell(|grant));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_to_flag && !clr_arb_to) |=> arb_to_flag);
endmodule

bind bus_arb_ctrl bus_arb_chk #(.N_LVL(N_LVL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sys_en      (sys_en),
  .mode_sel    (mode_sel),
  .bus_busy    (bus_busy),
  .clr_arb_to  (clr_arb_to),
  .grant       (grant),
  .arb_to_flag (arb_to_flag)
);

// File: tb/bus_arb_ctrl_test.sv
module bus_arb_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPU = 2;
  localparam int WD_US = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_en = 1'b0;
  logic [1:0] mode_sel = 2'd2;
  logic       long_to = 1'b0;
  logic [3:0] bus_req = 4'd0;
  logic       bus_busy = 1'b0;
  logic       xfer_strobe = 1'b0;
  logic       xfer_ack = 1'b0;
  logic       clr_arb_to = 1'b0;
  logic       clr_bus_to = 1'b0;
  logic [3:0] grant;
  logic       arb_to_flag, bus_to_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arb_ctrl #(.N_LVL(4), .TICKS_PER_US(TPU), .BUS_TO_US(WD_US)) uut (
    .clk(clk), .rst(rst), .sys_en(sys_en), .mode_sel(mode_sel),
    .long_to(long_to), .bus_req(bus_req), .bus_busy(bus_busy),
    .xfer_strobe(xfer_strobe), .xfer_ack(xfer_ack),
    .clr_arb_to(clr_arb_to), .clr_bus_to(clr_bus_to),
    .grant(grant), .arb_to_flag(arb_to_flag), .bus_to_flag(bus_to_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sys_en = 1'b1; bus_req = '0; bus_busy = 1'b0;
    xfer_strobe = 1'b0; xfer_ack = 1'b0; long_to = 1'b0;
    clr_arb_to = 1'b0; clr_bus_to = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // request, see the grant, then a master claims and releases the bus
  task automatic cycle_grant(input string tag, input logic [3:0] req, input int exp);
    bus_req = req;
    @(negedge clk);
    chk(tag, grant, exp);
    bus_busy = 1'b1; bus_req = '0;
    @(negedge clk);
    chk({tag, " drop on busy (R7)"}, grant, 0);
    bus_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant", grant, 0);
    chk("R1 arb flag", arb_to_flag, 0);
    chk("R1 bus flag", bus_to_flag, 0);
  endtask

  task automatic t_priority();
    do_reset(); mode_sel = 2'd2;
    cycle_grant("R4 req 0110", 4'b0110, 4);
    cycle_grant("R4 req 0011", 4'b0011, 2);
    cycle_grant("R4 req 1001", 4'b1001, 8);
    mode_sel = 2'd3;
    cycle_grant("R4 code3 req 0101", 4'b0101, 4);
    chk("R7 no timeout flag", arb_to_flag, 0);
  endtask

  task automatic t_single();
    do_reset(); mode_sel = 2'd1;
    bus_req = 4'b0111;
    repeat (4) @(negedge clk);
    chk("R5 low levels ignored", grant, 0);
    bus_req = '0;
    @(negedge clk);
    cycle_grant("R5 level 3", 4'b1111, 8);
  endtask

  task automatic t_rr();
    do_reset(); mode_sel = 2'd0;
    cycle_grant("R6 all 1st", 4'b1111, 8);
    cycle_grant("R6 all 2nd", 4'b1111, 4);
    cycle_grant("R6 all 3rd", 4'b1111, 2);
    cycle_grant("R6 all 4th", 4'b1111, 1);
    cycle_grant("R6 wrap", 4'b1111, 8);
    cycle_grant("R6 sparse a", 4'b0101, 4);
    cycle_grant("R6 sparse b", 4'b0101, 1);
    cycle_grant("R6 sparse c", 4'b0101, 4);
  endtask

  task automatic t_busy_block();
    do_reset(); mode_sel = 2'd2;
    bus_busy = 1'b1; bus_req = 4'b0010;
    repeat (5) @(negedge clk);
    chk("R3 held off by busy", grant, 0);
    bus_busy = 1'b0;
    @(negedge clk);
    chk("R3 grant after release", grant, 2);
    chk("R2 single grant", $countones(grant), 1);
    bus_busy = 1'b1; bus_req = '0;
    @(negedge clk);
    bus_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_timeout(input logic lng, input int exp_cyc);
    int held;
    do_reset(); mode_sel = 2'd2; long_to = lng;
    bus_req = 4'b0001;
    held = 0;
    @(negedge clk);
    while (grant != 0 && held < 1000) begin
      held++;
      if (held == exp_cyc - 1) chk("R8 flag not yet set", arb_to_flag, 0);
      @(negedge clk);
    end
    bus_req = '0;
    chk(lng ? "R8 long window cycles" : "R8 short window cycles", held, exp_cyc);
    chk("R8 flag set", arb_to_flag, 1);
    repeat (3) @(negedge clk);
    chk("R10 flag sticky", arb_to_flag, 1);
    clr_arb_to = 1'b1;
    @(negedge clk);
    clr_arb_to = 1'b0;
    chk("R10 flag cleared", arb_to_flag, 0);
  endtask

  task automatic t_watchdog();
    int lim;
    lim = WD_US * TPU;
    do_reset();
    xfer_strobe = 1'b1;
    repeat (lim - 1) @(negedge clk);
    chk("R9 not yet expired", bus_to_flag, 0);
    @(negedge clk);
    chk("R9 expired", bus_to_flag, 1);
    xfer_strobe = 1'b0;
    clr_bus_to = 1'b1;
    @(negedge clk);
    clr_bus_to = 1'b0;
    chk("R10 bus flag cleared", bus_to_flag, 0);
    xfer_strobe = 1'b1;
    repeat (lim - 3) @(negedge clk);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    repeat (lim - 3) @(negedge clk);
    chk("R9 ack restarts count", bus_to_flag, 0);
    xfer_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable();
    do_reset(); mode_sel = 2'd2;
    bus_req = 4'b0100;
    @(negedge clk);
    chk("R11 grant before disable", grant, 4);
    sys_en = 1'b0;
    @(negedge clk);
    chk("R11 grant withdrawn", grant, 0);
    xfer_strobe = 1'b1;
    repeat (WD_US * TPU + 4) @(negedge clk);
    chk("R11 stays inactive", grant, 0);
    chk("R11 watchdog idle", bus_to_flag, 0);
    xfer_strobe = 1'b0; bus_req = '0; sys_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_single();
    t_rr();
    t_busy_block();
    t_timeout(1'b0, 16 * TPU);
    t_timeout(1'b1, 256 * TPU);
    t_watchdog();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule